// File: doc/BRIEF.md
# Faulty-Block Column Remapper

This block sits beside a cache whose rows each hold several blocks side by side. It keeps a small bitmap with one bit per cache block, packed so that one stored word covers every block of one cache row. A configurator loads the words at test time, one row per write. On every cache access the bitmap word is looked up with only the row part of the cache index, at the same time as the data array is read. If the requested block is marked healthy the column passes through unchanged. If it is marked faulty the block returns a replacement column in the same row, and the column multiplexer of the cache is steered there instead.

The replacement follows a rank-matching rule. The faulty blocks of a row are ranked in ascending column order, and so are the healthy ones. The faulty block of rank k goes to the healthy block of rank k, wrapping round the healthy ones when they are fewer. This keeps the number of addresses that share one physical block as low as possible. A row with no healthy block is flagged as unusable, and a sticky flag records that such a row has been loaded since reset.

Top module: `remap_bitmap`

## Requirements
- R1: After reset every stored bit is 0, so no lookup redirects, `row_dead` is 0 and `any_dead` is 0.
- R2: A write with `cfg_we` high stores `cfg_bits` for row `cfg_row` at the clock edge. Bit c of the word describes column c, with 1 meaning faulty. Other rows keep their contents.
- R3: When the requested column's bit is 0, `redirect` is 0 and `repl_col` equals `lk_col`.
- R4: With exactly one faulty block in the row, an access to it is redirected to the lowest-numbered healthy column.
- R5: With two faulty blocks, the lower faulty column maps to the lower healthy column and the higher faulty column maps to the higher healthy column.
- R6: With three faulty blocks, every access to the row returns the single healthy column; the three faulty columns are redirected to it.
- R7: With every block of the row faulty, `row_dead` is 1, `redirect` is 0 and `repl_col` equals `lk_col`.
- R8: `any_dead` rises on the clock edge that writes an all-ones word and stays at 1 until reset, even if that row is later rewritten.
- R9: The lookup outputs depend combinationally on `lk_row` and `lk_col` with no added latency, and a row written at one edge is seen by lookups in the cycle that follows.
- R10: Whenever `redirect` is 1, `repl_col` names a column whose stored bit is 0 and differs from `lk_col`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the bitmap and the sticky flag |
| cfg_we | input | 1 | Configuration write enable |
| cfg_row | input | RW ($clog2(ROWS)) | Row written by the configurator |
| cfg_bits | input | COLS | Fault bits for that row, bit c for column c, 1 = faulty |
| lk_row | input | RW | Row address of the current access |
| lk_col | input | CW ($clog2(COLS)) | Requested column of the current access |
| redirect | output | 1 | Requested block is faulty and is replaced |
| repl_col | output | CW | Column the cache multiplexer should select |
| row_dead | output | 1 | Looked-up row has no healthy block |
| any_dead | output | 1 | Sticky: an all-faulty row has been written since reset |

## Verification
The hardest situation to reach from the ports is the full set of rank pairings, because each one needs a specific pattern of faulty blocks stored in a row and then a lookup of every column of that row. The bench writes all sixteen fault patterns into sixteen distinct rows, then sweeps every column of each, comparing against a model built from explicit lists of faulty and healthy columns. Separate scenarios rewrite a dead row with a healthy word to show the sticky flag holds, and check that neighbouring rows stay untouched by a write.

// File: rtl/remap_bitmap.sv
module remap_bitmap #(
  parameter int ROWS = 512,
  parameter int COLS = 4,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int NW = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_row,
  input  logic [COLS-1:0] cfg_bits,
  input  logic [RW-1:0] lk_row,
  input  logic [CW-1:0] lk_col,
  output logic          redirect,
  output logic [CW-1:0] repl_col,
  output logic          row_dead,
  output logic          any_dead
);

  logic [COLS-1:0] fmap [ROWS];
  logic [COLS-1:0] word;
  logic [NW-1:0]   nbad, rank, ngood, tgt, seen;
  logic [CW-1:0]   pick;
  logic            found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) fmap[r] <= '0;
      any_dead <= 1'b0;
    end else if (cfg_we) begin
      fmap[cfg_row] <= cfg_bits;
      if (&cfg_bits) any_dead <= 1'b1;
    end
  end

  assign word = fmap[lk_row];

  always_comb begin
    nbad = '0;
    rank = '0;
    for (int c = 0; c < COLS; c++) begin
      if (word[c]) begin
        nbad = nbad + NW'(1);
        if (CW'(c) < lk_col) rank = rank + NW'(1);
      end
    end
    ngood = NW'(COLS) - nbad;
    tgt   = (ngood == '0) ? '0 : rank % ngood;
    seen  = '0;
    found = 1'b0;
    pick  = lk_col;
    for (int c = 0; c < COLS; c++) begin
      if (!word[c]) begin
        if (!found && seen == tgt) begin
          pick  = CW'(c);
          found = 1'b1;
        end
        seen = seen + NW'(1);
      end
    end
  end

  assign row_dead = (ngood == '0);
  assign redirect = word[lk_col] && !row_dead;
  assign repl_col = redirect ? pick : lk_col;

  AST_TARGET_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!word[repl_col] && repl_col != lk_col)); // R10
  AST_DEAD_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    row_dead |-> (!redirect && repl_col == lk_col)); // R7
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (&cfg_bits)) |=> any_dead); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    any_dead |=> any_dead); // R8
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && lk_row == cfg_row) |=> ($past(lk_row) != lk_row) || (row_dead == (&$past(cfg_bits)))); // R9
  AST_GOOD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> repl_col == lk_col); // R3

endmodule

// File: tb/remap_bitmap_tb.sv
module remap_bitmap_tb;
  localparam int ROWS = 512;
  localparam int COLS = 4;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [RW-1:0] cfg_row = '0;
  logic [COLS-1:0] cfg_bits = '0;
  logic [RW-1:0] lk_row = '0;
  logic [CW-1:0] lk_col = '0;
  logic redirect, row_dead, any_dead;
  logic [CW-1:0] repl_col;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  remap_bitmap #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_bits(cfg_bits),
    .lk_row(lk_row), .lk_col(lk_col), .redirect(redirect), .repl_col(repl_col),
    .row_dead(row_dead), .any_dead(any_dead));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int row, input logic [COLS-1:0] bits);
    @(negedge clk);
    cfg_row = RW'(row);
    cfg_bits = bits;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input int row, input int col);
    lk_row = RW'(row);
    lk_col = CW'(col);
    #1;
  endtask

  // expected column from explicit faulty/healthy lists
  function automatic int exp_col(input logic [COLS-1:0] bits, input int col);
    int bad[COLS];
    int good[COLS];
    int nb = 0;
    int ng = 0;
    int k = 0;
    for (int c = 0; c < COLS; c++) begin
      if (bits[c]) begin bad[nb] = c; nb++; end
      else begin good[ng] = c; ng++; end
    end
    if (!bits[col] || ng == 0) return col;
    for (int i = 0; i < nb; i++) if (bad[i] == col) k = i;
    return good[k % ng];
  endfunction

  task automatic t_reset;
    for (int r = 0; r < ROWS; r += 97) begin
      for (int c = 0; c < COLS; c++) begin
        look(r, c);
        check("R1 redirect after reset", int'(redirect), 0);
      end
    end
    check("R1 row_dead after reset", int'(row_dead), 0);
    check("R1 any_dead after reset", int'(any_dead), 0);
  endtask

  task automatic t_directed;
    wr(10, 4'b0100);
    look(10, 2); check("R4 single fault redirect", int'(redirect), 1);
    check("R4 single fault column", int'(repl_col), 0);
    look(10, 3); check("R3 healthy passes", int'(repl_col), 3);
    check("R3 healthy no redirect", int'(redirect), 0);
    wr(11, 4'b0011);
    look(11, 0); check("R5 lower faulty to lower good", int'(repl_col), 2);
    look(11, 1); check("R5 higher faulty to higher good", int'(repl_col), 3);
    wr(12, 4'b1011);
    for (int c = 0; c < COLS; c++) begin
      look(12, c); check("R6 three faults single good", int'(repl_col), 2);
    end
    look(9, 2); check("R2 neighbour row untouched", int'(redirect), 0);
    look(13, 0); check("R2 neighbour row untouched", int'(redirect), 0);
  endtask

  task automatic t_dead;
    check("R8 flag low before dead write", int'(any_dead), 0);
    @(negedge clk);
    cfg_row = RW'(300); cfg_bits = '1; cfg_we = 1'b1;
    lk_row = RW'(300); lk_col = CW'(1);
    #1;
    check("R9 write not visible before edge", int'(row_dead), 0);
    @(posedge clk); #1;
    check("R9 write visible after edge", int'(row_dead), 1);
    check("R8 flag rises at write edge", int'(any_dead), 1);
    @(negedge clk); cfg_we = 1'b0;
    look(300, 1);
    check("R7 dead row no redirect", int'(redirect), 0);
    check("R7 dead row passes column", int'(repl_col), 1);
    wr(300, 4'b0000);
    look(300, 1);
    check("R2 rewrite clears row", int'(row_dead), 0);
    check("R8 flag stays after rewrite", int'(any_dead), 1);
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 16; p++) wr(400 + p, 4'(p));
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < COLS; c++) begin
        look(400 + p, c);
        check("R10 sweep column", int'(repl_col), exp_col(4'(p), c));
        check("R10 sweep redirect", int'(redirect), int'(p[c] && p != 15));
        check("R7 sweep dead", int'(row_dead), int'(p == 15));
        if (redirect) check("R10 target healthy", int'(p[repl_col]), 0);
      end
    end
  endtask

  task automatic t_rereset;
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 flag cleared by reset", int'(any_dead), 0);
    look(11, 0);
    check("R1 bitmap cleared by reset", int'(redirect), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_dead();
    t_sweep();
    t_rereset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule